// File: doc/BRIEF.md
# Power-Up Register Write Sequencer

This block brings a timing-generator core into operation after reset. It issues an ordered series of register writes through a simple write port: an address, a data byte, and a write strobe that stays asserted until the receiver answers with a ready pulse. A serializer downstream of the port carries each write to the core. The sequencer does not care how that happens.

The fixed writes wrap a block of timing writes supplied by the user. After the soft reset write, the block drains a small FIFO of user address/data pairs. A count input sets how many FIFO entries belong to the block. After the user block, the power, test, oscillator and core bring-up writes follow. Two inputs select the closing steps. The master/slave input decides whether the master-configuration write is issued. The software-sync input decides whether a write that fires an internal sync pulse ends the sequence. A done flag and a step index report progress.

The mode, sync selection and user count are sampled once, in the first cycle after reset is released. Changing them later has no effect on the running sequence.

Top module: `pwrup_wr_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, `wr_valid_o` and `done_o` are low and `step_o` is 0.
- R2: The first write is address 0x010 with data 0x01 (soft reset of all registers).
- R3: After the soft reset, exactly `usr_cnt_i` FIFO entries are consumed in push order, each written with its own address and data. A count of 0 skips the user block.
- R4: A FIFO entry whose address is below 0x020 is discarded without a write, and it still counts as one of the `usr_cnt_i` entries.
- R5: After the user block come these writes, in this order: 0x000/0x04, 0x0EA/0x60, 0x016/0x01, 0x015/0x01.
- R6: In master mode (`master_i`=1), 0x020/0x01 follows the 0x015 write. In slave mode this write is skipped.
- R7: The next write is 0x011/0x01 (outputs enabled after sync).
- R8: Only when master mode and software sync (`soft_sync_i`=1) are both selected does 0x013/0x01 follow as the last write. Otherwise the sequence ends after the 0x011 write.
- R9: While `wr_valid_o` is high and `wr_ready_i` is low, `wr_valid_o`, `wr_addr_o` and `wr_data_o` hold their values. The sequencer advances only on a cycle in which both are high.
- R10: While user entries are still owed and the FIFO is empty, `wr_valid_o` stays low and `step_o` reads 2.
- R11: `done_o` rises in the cycle after the last write is accepted. It then stays high, with `wr_valid_o` low, until the next reset.
- R12: `step_o` encodes progress as: 0 idle, 1 soft reset, 2 user block, 3 power-up, 4 test value, 5 oscillator reset, 6 core reset, 7 master select, 8 output enable, 9 sync, 10 done.
- R13: `usr_full_o` is high when the FIFO holds `FIFO_DEPTH` entries. A push while it is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 selects master mode, 0 selects slave mode |
| soft_sync_i | input | 1 | 1 ends a master sequence with the internal sync write |
| usr_cnt_i | input | CNT_W | Number of user FIFO entries to drain |
| usr_wr_i | input | 1 | Push strobe for the user FIFO |
| usr_addr_i | input | 12 | User entry address |
| usr_data_i | input | 8 | User entry data |
| usr_full_o | output | 1 | User FIFO full |
| wr_addr_o | output | 12 | Write address |
| wr_data_o | output | 8 | Write data |
| wr_valid_o | output | 1 | Write strobe, held until accepted |
| wr_ready_i | input | 1 | Write accepted by the receiver |
| done_o | output | 1 | Sequence finished |
| step_o | output | 4 | Current step index |

## Verification
The bench builds the block with `FIFO_DEPTH`=4 and the default 8-bit count. With this depth the FIFO fills after only a few pushes, so the dropped fifth push can be seen in the output: the write that follows the user block must be the power-up write, not that entry. The scenarios cover master with sync, master without sync, and slave with a zero count. They also cover a user block that stalls on an empty FIFO and ready delays of zero to two cycles, so the hold behaviour is exercised on both fixed and user writes.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_SWRST  = 4'd1,
    ST_USER   = 4'd2,
    ST_AFE    = 4'd3,
    ST_TEST   = 4'd4,
    ST_OSC    = 4'd5,
    ST_CORE   = 4'd6,
    ST_MASTER = 4'd7,
    ST_OUTEN  = 4'd8,
    ST_SYNC   = 4'd9,
    ST_DONE   = 4'd10
  } seq_st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_word_t;

  function automatic wr_word_t fixed_word(seq_st_e s);
    wr_word_t w;
    w = '0;
    case (s)
      ST_SWRST:  w = '{addr: 12'h010, data: 8'h01};
      ST_AFE:    w = '{addr: 12'h000, data: 8'h04};
      ST_TEST:   w = '{addr: 12'h0EA, data: 8'h60};
      ST_OSC:    w = '{addr: 12'h016, data: 8'h01};
      ST_CORE:   w = '{addr: 12'h015, data: 8'h01};
      ST_MASTER: w = '{addr: 12'h020, data: 8'h01};
      ST_OUTEN:  w = '{addr: 12'h011, data: 8'h01};
      ST_SYNC:   w = '{addr: 12'h013, data: 8'h01};
      default:   w = '0;
    endcase
    return w;
  endfunction

  function automatic seq_st_e fixed_next(seq_st_e s, logic master, logic sync);
    seq_st_e n;
    case (s)
      ST_SWRST:  n = ST_USER;
      ST_AFE:    n = ST_TEST;
      ST_TEST:   n = ST_OSC;
      ST_OSC:    n = ST_CORE;
      ST_CORE:   n = master ? ST_MASTER : ST_OUTEN;
      ST_MASTER: n = ST_OUTEN;
      ST_OUTEN:  n = (master && sync) ? ST_SYNC : ST_DONE;
      ST_SYNC:   n = ST_DONE;
      default:   n = s;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/pwrup_usr_fifo.sv
module pwrup_usr_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_ptr_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + PTR_W'(1);
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + PTR_W'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R13: occupancy never passes the depth
  a_r13_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R13: a push into a full FIFO leaves the count unchanged unless popped
  a_r13_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> full_o);
endmodule

// File: rtl/pwrup_seq_ctrl.sv
module pwrup_seq_ctrl
  import pwrup_seq_pkg::*;
#(
  parameter int                CNT_W        = 8,
  parameter logic [ADDR_W-1:0] MIN_USR_ADDR = 12'h020
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              soft_sync_i,
  input  logic [CNT_W-1:0]  usr_cnt_i,
  input  wr_word_t          head_i,
  input  logic              head_vld_i,
  output logic              pop_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic              done_o,
  output logic [3:0]        step_o
);
  seq_st_e          state_q, state_d;
  logic             master_q, sync_q;
  logic [CNT_W-1:0] remain_q;
  logic             usr_pend, head_ok, fire;
  wr_word_t         word;

  always_comb begin
    usr_pend   = (state_q == ST_USER) && (remain_q != '0);
    head_ok    = head_vld_i && (head_i.addr >= MIN_USR_ADDR);
    word       = (state_q == ST_USER) ? head_i : fixed_word(state_q);
    wr_valid_o = (state_q == ST_USER) ? (usr_pend && head_ok)
                                      : !(state_q inside {ST_IDLE, ST_DONE});
    fire       = wr_valid_o && wr_ready_i;
    // low-address entries are dropped without a write
    pop_o      = usr_pend && head_vld_i && (!head_ok || wr_ready_i);
    state_d    = state_q;
    case (state_q)
      ST_IDLE: state_d = ST_SWRST;
      ST_USER: if (!usr_pend) state_d = ST_AFE;
      ST_DONE: state_d = ST_DONE;
      default: if (fire) state_d = fixed_next(state_q, master_q, sync_q);
    endcase
  end

  assign wr_addr_o = word.addr;
  assign wr_data_o = word.data;
  assign done_o    = (state_q == ST_DONE);
  assign step_o    = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      master_q <= 1'b0;
      sync_q   <= 1'b0;
      remain_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE) begin
        master_q <= master_i;
        sync_q   <= soft_sync_i;
        remain_q <= usr_cnt_i;
      end else if (pop_o) begin
        remain_q <= remain_q - CNT_W'(1);
      end
    end
  end

  // R9: an unaccepted write holds address, data and strobe
  a_r9_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));
  // R11: done is sticky and silences the port
  a_r11_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  a_r11_quiet_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !wr_valid_o);
  // R4: no user write below the timing address window
  a_r4_user_addr_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && step_o == 4'd2) |-> (wr_addr_o >= MIN_USR_ADDR));
  // R6: slave mode never reaches the master-select step
  a_r6_slave_skips_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == 4'd6 && !master_q && fire) |=> (step_o == 4'd8));
  // R8: the sync step only follows the output-enable step in master mode
  a_r8_sync_only_master: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == 4'd9) |-> (master_q && sync_q));
  // R10: no strobe while waiting on an empty FIFO
  a_r10_wait_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o == 4'd2 && !head_vld_i) |-> !wr_valid_o);
endmodule

// File: rtl/pwrup_wr_seq.sv
module pwrup_wr_seq
  import pwrup_seq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              soft_sync_i,
  input  logic [CNT_W-1:0]  usr_cnt_i,
  input  logic              usr_wr_i,
  input  logic [ADDR_W-1:0] usr_addr_i,
  input  logic [DATA_W-1:0] usr_data_i,
  output logic              usr_full_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic              done_o,
  output logic [3:0]        step_o
);
  localparam int WORD_W = $bits(wr_word_t);

  wr_word_t push_word, head;
  logic     fifo_empty, pop;

  assign push_word = '{addr: usr_addr_i, data: usr_data_i};

  pwrup_usr_fifo #(
    .DEPTH (FIFO_DEPTH),
    .W     (WORD_W)
  ) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (usr_wr_i),
    .push_data_i (push_word),
    .pop_i       (pop),
    .head_o      (head),
    .empty_o     (fifo_empty),
    .full_o      (usr_full_o)
  );

  pwrup_seq_ctrl #(
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .master_i    (master_i),
    .soft_sync_i (soft_sync_i),
    .usr_cnt_i   (usr_cnt_i),
    .head_i      (head),
    .head_vld_i  (!fifo_empty),
    .pop_o       (pop),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .wr_valid_o  (wr_valid_o),
    .wr_ready_i  (wr_ready_i),
    .done_o      (done_o),
    .step_o      (step_o)
  );
endmodule

// File: tb/pwrup_wr_seq_bench.sv
module pwrup_wr_seq_bench;
  localparam int DEPTH = 4;
  localparam int CW    = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          master_i = 1'b0, soft_sync_i = 1'b0;
  logic [CW-1:0] usr_cnt_i = '0;
  logic          usr_wr_i = 1'b0;
  logic [11:0]   usr_addr_i = '0;
  logic [7:0]    usr_data_i = '0;
  logic          usr_full_o, wr_valid_o, done_o;
  logic          wr_ready_i = 1'b0;
  logic [11:0]   wr_addr_o;
  logic [7:0]    wr_data_o;
  logic [3:0]    step_o;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  pwrup_wr_seq #(.FIFO_DEPTH(DEPTH), .CNT_W(CW)) u_pwrup_wr_seq (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master_i), .soft_sync_i(soft_sync_i),
    .usr_cnt_i(usr_cnt_i), .usr_wr_i(usr_wr_i), .usr_addr_i(usr_addr_i),
    .usr_data_i(usr_data_i), .usr_full_o(usr_full_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .done_o(done_o), .step_o(step_o));

  // master + soft sync, user block {020/A1, 005/77 dropped, FFF/3C}
  localparam logic [19:0] VEC [10] = '{
    {12'h010, 8'h01}, {12'h020, 8'hA1}, {12'hFFF, 8'h3C}, {12'h000, 8'h04},
    {12'h0EA, 8'h60}, {12'h016, 8'h01}, {12'h015, 8'h01}, {12'h020, 8'h01},
    {12'h011, 8'h01}, {12'h013, 8'h01}};

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m, input logic s, input logic [CW-1:0] c);
    @(negedge clk);
    rst_ni = 1'b0; master_i = m; soft_sync_i = s; usr_cnt_i = c; wr_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!wr_valid_o && !done_o && step_o == 4'd0, "R1 reset outputs",
        {27'd0, wr_valid_o, done_o, step_o}, 32'd0);
    rst_ni = 1'b1;
    chk(step_o == 4'd0 && !wr_valid_o, "R1 first cycle", {27'd0, wr_valid_o, 4'd0}, 32'd0);
  endtask

  task automatic push(input logic [11:0] a, input logic [7:0] d);
    usr_wr_i = 1'b1; usr_addr_i = a; usr_data_i = d;
    @(negedge clk);
    usr_wr_i = 1'b0;
  endtask

  task automatic serve(input logic [11:0] ea, input logic [7:0] ed, input int dly, input string req);
    while (!wr_valid_o) @(negedge clk);
    chk(wr_addr_o == ea && wr_data_o == ed, req, {12'd0, wr_addr_o, wr_data_o}, {12'd0, ea, ed});
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk(wr_valid_o && wr_addr_o == ea && wr_data_o == ed, "R9 hold",
          {11'd0, wr_valid_o, wr_addr_o, wr_data_o}, {11'd1, ea, ed});
    end
    wr_ready_i = 1'b1;
    @(negedge clk);
    wr_ready_i = 1'b0;
  endtask

  function automatic string vreq(int i);
    if (i == 0) return "R2 soft reset";
    if (i < 3)  return "R3/R4 user block";
    if (i < 7)  return "R5 fixed order";
    if (i == 7) return "R6 master select";
    if (i == 8) return "R7 output enable";
    return "R8 sync write";
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // table walk: master with software sync
    do_reset(1'b1, 1'b1, 8'd3);
    push(12'h020, 8'hA1); push(12'h005, 8'h77); push(12'hFFF, 8'h3C);
    for (int i = 0; i < 10; i++) serve(VEC[i][19:8], VEC[i][7:0], i % 3, vreq(i));
    chk(done_o && !wr_valid_o, "R11 done after sync", {30'd0, done_o, wr_valid_o}, 32'h2);
    chk(step_o == 4'd10, "R12 done step", {28'd0, step_o}, 32'd10);

    // slave, zero count: no master select, no sync
    do_reset(1'b0, 1'b1, 8'd0);
    serve(12'h010, 8'h01, 0, "R2 slave");
    serve(12'h000, 8'h04, 1, "R3 count zero skip");
    serve(12'h0EA, 8'h60, 0, "R5 slave");
    serve(12'h016, 8'h01, 0, "R5 slave");
    serve(12'h015, 8'h01, 0, "R5 slave");
    serve(12'h011, 8'h01, 0, "R6 slave skips master");
    chk(done_o, "R8 slave ends at output enable", {31'd0, done_o}, 32'd1);
    for (int k = 0; k < 6; k++) begin
      wr_ready_i = k[0];
      @(negedge clk);
    end
    wr_ready_i = 1'b0;
    chk(done_o && !wr_valid_o && step_o == 4'd10, "R11 done held",
        {27'd0, done_o, wr_valid_o, step_o}, {27'd0, 1'b1, 1'b0, 4'd10});

    // master, no soft sync, empty FIFO stall
    do_reset(1'b1, 1'b0, 8'd1);
    serve(12'h010, 8'h01, 0, "R2 master nosync");
    repeat (4) @(negedge clk);
    chk(!wr_valid_o && step_o == 4'd2, "R10 empty wait", {27'd0, wr_valid_o, step_o}, 32'd2);
    push(12'h123, 8'h5A);
    serve(12'h123, 8'h5A, 2, "R3 late entry");
    serve(12'h000, 8'h04, 0, "R5 nosync");
    serve(12'h0EA, 8'h60, 0, "R5 nosync");
    serve(12'h016, 8'h01, 0, "R5 nosync");
    serve(12'h015, 8'h01, 0, "R5 nosync");
    serve(12'h020, 8'h01, 0, "R6 master nosync");
    serve(12'h011, 8'h01, 0, "R7 nosync");
    chk(done_o && !wr_valid_o, "R8 no sync write", {30'd0, done_o, wr_valid_o}, 32'h2);

    // FIFO full: fifth push dropped
    do_reset(1'b0, 1'b0, 8'(DEPTH));
    for (int i = 0; i <= DEPTH; i++) push(12'h100 + 12'(i), 8'(i));
    chk(usr_full_o, "R13 full flag", {31'd0, usr_full_o}, 32'd1);
    serve(12'h010, 8'h01, 0, "R2 full case");
    for (int i = 0; i < DEPTH; i++) serve(12'h100 + 12'(i), 8'(i), 0, "R13 kept entries");
    serve(12'h000, 8'h04, 0, "R13 extra push dropped");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule